// File: doc/BRIEF.md
# Multi-rate retention-aware refresh scheduler

This block decides which DRAM rows to refresh in each base retention window. It does not refresh every row every window. Each row falls into one of three retention classes: fast (every window), middle (every second window) and slow (every fourth window). Two Bloom filters hold the class of each row. One filter holds the rows that need the fast rate and the other holds the rows that need the middle rate. Any row found in neither filter gets the slow default rate. A false positive in a filter can only add refreshes. It never removes one.

A pulse on the window tick starts one sweep over the whole row space. The sweep visits the rows in ascending order. For each row it probes both filters and computes whether the row is due in this window. The due test uses the window number and the row's low address bits, so no timestamp is kept for any row. A refresh that is due is presented on the command port as a row and bank pair. The request is held until the command bus grants it. The scheduler also keeps a per-bank occupancy timer, so that one bank is never sent a second refresh while it is still busy with the previous one.

Top module: `rr_refresh_ctrl`

## Requirements
- R1: After reset `ref_req_o` is 0, and no refresh is requested until the first window tick.
- R2: Each filter is a `FILT_M`-bit vector.
  - Programming an address sets `HASH_K` bits. Bit `j` is at index `h_j(a)`.
  - `h_j(a)` is built from `v`, which is `a` rotated left by `(j*HASH_ROT) mod ADDR_W`. Bit `b` of `h_j(a)` is the XOR of every `v[i]` with `i mod log2(FILT_M) == b`.
  - A probe hits only when all `HASH_K` bits are set.
- R3: A window tick that arrives while the scheduler is idle starts one sweep over the addresses 0 to 2^ADDR_W-1 in ascending order.
  - The sweep issues at most one command per address.
  - The first window after reset is window 0. The window number then counts modulo 4.
- R4: A row that hits the fast filter is refreshed in every window.
- R5: A row that hits only the middle filter is refreshed in the windows where bit 0 of the window equals bit 0 of its row field.
- R6: A row that hits both filters follows the fast rate and is refreshed in every window.
- R7: A row that hits neither filter is refreshed when bits 1:0 of the window equal bits 1:0 of its row field.
- R8: A sweep address `a` is split into a bank field and a row field. `ref_bank_o` carries `a[BANK_W-1:0]` and `ref_row_o` carries `a[ADDR_W-1:BANK_W]`.
- R9: A command is issued in a cycle where both `ref_req_o` and `bus_gnt_i` are high. While the grant is low, the request, row and bank hold their values.
- R10: Two commands to the same bank are issued at least `BUSY_CYC` cycles apart.
- R11: A window tick that arrives while a sweep is in progress is ignored. It neither restarts the sweep nor advances the window number.
- R12: A clear on the programming port (`prog_clr_i`=1) empties only the filter chosen by `prog_sel_i`. A value of 0 selects the fast filter and 1 selects the middle filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_tick_i | input | 1 | One-cycle pulse at the start of each base window |
| prog_en_i | input | 1 | Filter programming strobe |
| prog_clr_i | input | 1 | With the strobe: 1 clears the selected filter, 0 inserts an address |
| prog_sel_i | input | 1 | Filter select: 0 selects the fast filter, 1 selects the middle filter |
| prog_addr_i | input | ROW_W+BANK_W | Address to insert |
| ref_req_o | output | 1 | Refresh command valid |
| ref_row_o | output | ROW_W | Row of the command |
| ref_bank_o | output | BANK_W | Bank of the command |
| bus_gnt_i | input | 1 | Command bus grant |

## Verification
The bench sweeps four consecutive windows with a mix of fast-only, middle-only, both-class and unprogrammed rows. It compares every issued address against its own filter and phase model.
- A scheduler that let the middle class override the fast one would drop a both-class row in odd windows.
- A scheduler that used the wrong phase bits would shift the default refreshes to the wrong rows.
- A tick injected in the middle of a sweep is followed by a sweep that must use the next window number. A design that restarts the sweep or advances the window on that tick would emit duplicate or wrong-phase commands.
- A clear of the fast filter alone must leave the middle-class rows unchanged.

The bench stalls the grant periodically. A design that let the request or address drift during a stall, or that sent a command to a bank before its busy time ran out, fails the per-command hold and spacing checks.

// File: rtl/rr_refresh_pkg.sv
package rr_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_REQ  = 2'd2
  } sweep_st_e;

  localparam int unsigned WIN_W = 2;  // window number counts mod 4
endpackage

// File: rtl/rr_bloom_filter.sv
module rr_bloom_filter #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned FILT_M   = 32,
  parameter int unsigned HASH_K   = 2,
  parameter int unsigned HASH_ROT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              hit_o
);
  localparam int unsigned IDX_W = $clog2(FILT_M);

  function automatic logic [IDX_W-1:0] hash_idx(input logic [ADDR_W-1:0] a, input int unsigned j);
    logic [ADDR_W-1:0] v;
    logic [IDX_W-1:0]  h;
    int unsigned       r;
    r = (j * HASH_ROT) % ADDR_W;
    v = (a << r) | (a >> (ADDR_W - r));
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % IDX_W] ^= v[i];
    return h;
  endfunction

  logic [FILT_M-1:0]             bits_q;
  logic [HASH_K-1:0][IDX_W-1:0]  ins_idx;
  logic [HASH_K-1:0][IDX_W-1:0]  prb_idx;
  logic [HASH_K-1:0]             prb_set;

  for (genvar j = 0; j < HASH_K; j++) begin : g_hash
    assign ins_idx[j] = hash_idx(ins_addr_i, j);
    assign prb_idx[j] = hash_idx(probe_addr_i, j);
    assign prb_set[j] = bits_q[prb_idx[j]];

    AST_INS_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ins_i && !clr_i |=> bits_q[$past(ins_idx[j])]);  // R2
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
    end else if (ins_i) begin
      for (int j = 0; j < HASH_K; j++) bits_q[ins_idx[j]] <= 1'b1;
    end
  end

  assign hit_o = &prb_set;

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bits_q == '0));  // R12
endmodule

// File: rtl/rr_bank_timer.sv
module rr_bank_timer #(
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned BUSY_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] load_bank_i,
  input  logic [BANK_W-1:0] chk_bank_i,
  output logic              free_o
);
  localparam int unsigned NBANK = 1 << BANK_W;
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  logic [NBANK-1:0][CNT_W-1:0] cnt_q;
  logic [NBANK-1:0]            free_vec;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // loaded with BUSY_CYC-1 so the next issue lands BUSY_CYC cycles later
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      cnt_q[b] <= '0;
      else if (load_i && load_bank_i == BANK_W'(b))     cnt_q[b] <= CNT_W'(BUSY_CYC - 1);
      else if (cnt_q[b] != '0)                          cnt_q[b] <= cnt_q[b] - 1'b1;
    end
    assign free_vec[b] = (cnt_q[b] == '0);

    AST_LOAD_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i && load_bank_i == BANK_W'(b) |-> cnt_q[b] == '0);  // R10

    if (BUSY_CYC > 1) begin : g_hold
      AST_BUSY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && load_bank_i == BANK_W'(b) |=> !free_vec[b]);  // R10
    end
  end

  assign free_o = free_vec[chk_bank_i];
endmodule

// File: rtl/rr_refresh_ctrl.sv
module rr_refresh_ctrl #(
  parameter int unsigned ROW_W    = 6,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned FILT_M   = 32,
  parameter int unsigned HASH_K   = 2,
  parameter int unsigned HASH_ROT = 3,
  parameter int unsigned BUSY_CYC = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    win_tick_i,
  input  logic                    prog_en_i,
  input  logic                    prog_clr_i,
  input  logic                    prog_sel_i,
  input  logic [ROW_W+BANK_W-1:0] prog_addr_i,
  output logic                    ref_req_o,
  output logic [ROW_W-1:0]        ref_row_o,
  output logic [BANK_W-1:0]       ref_bank_o,
  input  logic                    bus_gnt_i
);
  import rr_refresh_pkg::*;

  localparam int unsigned ADDR_W = ROW_W + BANK_W;
  localparam int unsigned NFILT  = 2;  // 0: fast class, 1: middle class

  sweep_st_e         st_q;
  logic [ADDR_W-1:0] idx_q;
  logic [WIN_W-1:0]  win_q;
  logic [NFILT-1:0]  hit;
  logic              fast_hit, mid_hit;
  logic [1:0]        row_ph;
  logic              need, last, bank_free, issue;

  for (genvar k = 0; k < NFILT; k++) begin : g_filt
    rr_bloom_filter #(
      .ADDR_W  (ADDR_W),
      .FILT_M  (FILT_M),
      .HASH_K  (HASH_K),
      .HASH_ROT(HASH_ROT)
    ) u_filt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ins_i       (prog_en_i && !prog_clr_i && prog_sel_i == 1'(k)),
      .clr_i       (prog_en_i && prog_clr_i && prog_sel_i == 1'(k)),
      .ins_addr_i  (prog_addr_i),
      .probe_addr_i(idx_q),
      .hit_o       (hit[k])
    );
  end

  assign fast_hit = hit[0];
  assign mid_hit  = hit[1];
  assign row_ph   = idx_q[BANK_W +: 2];
  assign need     = fast_hit
                  | (mid_hit && (win_q[0] == row_ph[0]))
                  | (win_q == row_ph);
  assign last     = (idx_q == '1);

  rr_bank_timer #(
    .BANK_W  (BANK_W),
    .BUSY_CYC(BUSY_CYC)
  ) u_bank_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (issue),
    .load_bank_i(idx_q[BANK_W-1:0]),
    .chk_bank_i (idx_q[BANK_W-1:0]),
    .free_o     (bank_free)
  );

  assign ref_req_o  = (st_q == ST_REQ) && bank_free;
  assign issue      = ref_req_o && bus_gnt_i;
  assign ref_row_o  = idx_q[ADDR_W-1:BANK_W];
  assign ref_bank_o = idx_q[BANK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      win_q <= '1;  // first tick yields window 0
    end else begin
      unique case (st_q)
        ST_IDLE: if (win_tick_i) begin
          win_q <= win_q + 1'b1;
          idx_q <= '0;
          st_q  <= ST_EVAL;
        end
        ST_EVAL: begin
          if (need)      st_q  <= ST_REQ;
          else if (last) st_q  <= ST_IDLE;
          else           idx_q <= idx_q + 1'b1;
        end
        ST_REQ: if (issue) begin
          if (last) st_q <= ST_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_EVAL;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !bus_gnt_i |=> ref_req_o && $stable(ref_row_o) && $stable(ref_bank_o));  // R9

  AST_TICK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE && win_tick_i |=> $stable(win_q));  // R11

  AST_FAST_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EVAL && fast_hit |=> st_q == ST_REQ && $stable(idx_q));  // R4

  AST_DEFAULT_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EVAL && win_q == row_ph |=> st_q == ST_REQ);  // R7

  AST_SWEEP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && !last |=> st_q == ST_EVAL && idx_q == $past(idx_q) + 1'b1);  // R3
endmodule

// File: tb/rr_refresh_ctrl_tb.sv
module rr_refresh_ctrl_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ROW_W = 6, BANK_W = 2, FILT_M = 32, HASH_K = 2, HASH_ROT = 3, BUSY_CYC = 16;
  localparam int unsigned ADDR_W = ROW_W + BANK_W;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned NADDR = 1 << ADDR_W;
  localparam int unsigned WIN_CYC = 3000;

  // {sel, clr, addr}: sel 0 = fast filter, 1 = middle filter
  localparam logic [9:0] PROG_TAB [8] = '{
    {1'b0, 1'b0, 8'h13}, {1'b0, 1'b0, 8'h40}, {1'b1, 1'b0, 8'h40}, {1'b1, 1'b0, 8'h21},
    {1'b1, 1'b0, 8'h77}, {1'b1, 1'b0, 8'hc6}, {1'b0, 1'b0, 8'he9}, {1'b0, 1'b0, 8'h05}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic win_tick = 1'b0, prog_en = 1'b0, prog_clr = 1'b0, prog_sel = 1'b0;
  logic [ADDR_W-1:0] prog_addr = '0;
  logic ref_req, bus_gnt = 1'b0;
  logic [ROW_W-1:0] ref_row;
  logic [BANK_W-1:0] ref_bank;

  int n_checks = 0, n_fail = 0, cyc = 0, n_cmd = 0;
  logic [ADDR_W-1:0] cmd_addr [NADDR];
  int last_cyc [1 << BANK_W];
  logic [FILT_M-1:0] m_bits [2];
  logic prev_wait = 1'b0;
  logic [ROW_W-1:0] prev_row;
  logic [BANK_W-1:0] prev_bank;

  rr_refresh_ctrl #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .FILT_M(FILT_M),
    .HASH_K(HASH_K), .HASH_ROT(HASH_ROT), .BUSY_CYC(BUSY_CYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .win_tick_i(win_tick),
    .prog_en_i(prog_en), .prog_clr_i(prog_clr), .prog_sel_i(prog_sel), .prog_addr_i(prog_addr),
    .ref_req_o(ref_req), .ref_row_o(ref_row), .ref_bank_o(ref_bank), .bus_gnt_i(bus_gnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // grant stalls every seventh cycle
  initial forever begin
    @(posedge clk);
    #1;
    cyc = cyc + 1;
    bus_gnt = (cyc % 7) != 3;
  end

  // R2 hash as stated in the requirement
  function automatic logic [IDX_W-1:0] hidx(input logic [ADDR_W-1:0] a, input int j);
    logic [ADDR_W-1:0] v;
    logic [IDX_W-1:0] h;
    int r;
    r = (j * HASH_ROT) % ADDR_W;
    v = (a << r) | (a >> (ADDR_W - r));
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % IDX_W] ^= v[i];
    return h;
  endfunction

  function automatic logic m_hit(input int s, input logic [ADDR_W-1:0] a);
    logic ok = 1'b1;
    for (int j = 0; j < HASH_K; j++) ok &= m_bits[s][hidx(a, j)];
    return ok;
  endfunction

  function automatic int due_class(input logic [ADDR_W-1:0] a, input int w);
    logic [1:0] ph;
    ph = a[BANK_W +: 2];
    if (m_hit(0, a) && m_hit(1, a)) return 6;
    if (m_hit(0, a)) return 4;
    if (m_hit(1, a) && ph[0] == w[0]) return 5;
    if (ph == w[1:0]) return 7;
    return 0;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // command monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait)  // R9
        check(ref_req && ref_row == prev_row && ref_bank == prev_bank, "R9 hold",
              {ref_req, ref_row, ref_bank}, {1'b1, prev_row, prev_bank});
      if (ref_req && bus_gnt) begin
        if (n_cmd < NADDR) cmd_addr[n_cmd] = {ref_row, ref_bank};
        n_cmd++;
        if (last_cyc[ref_bank] >= 0)  // R10
          check(cyc - last_cyc[ref_bank] >= BUSY_CYC, "R10 spacing",
                cyc - last_cyc[ref_bank], BUSY_CYC);
        last_cyc[ref_bank] = cyc;
      end
      prev_wait = ref_req && !bus_gnt;
      prev_row  = ref_row;
      prev_bank = ref_bank;
    end
  end

  task automatic prog(input logic sel, input logic clr, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    prog_en = 1'b1; prog_sel = sel; prog_clr = clr; prog_addr = a;
    @(negedge clk);
    prog_en = 1'b0; prog_clr = 1'b0;
    if (clr) m_bits[sel] = '0;
    else for (int j = 0; j < HASH_K; j++) m_bits[sel][hidx(a, j)] = 1'b1;
  endtask

  task automatic run_window(input int w, input bit extra_tick);
    int ne, cls;
    string tag;
    n_cmd = 0;
    @(negedge clk); win_tick = 1'b1;
    @(negedge clk); win_tick = 1'b0;
    repeat (20) @(negedge clk);
    if (extra_tick) begin  // R11: tick during sweep
      win_tick = 1'b1;
      @(negedge clk); win_tick = 1'b0;
    end
    repeat (WIN_CYC) @(negedge clk);
    ne = 0;
    for (int a = 0; a < NADDR; a++) begin
      cls = due_class(a[ADDR_W-1:0], w);
      if (cls != 0) begin
        tag = (cls == 4) ? "R2 R4 fast R8" : (cls == 5) ? "R2 R5 mid R8" :
              (cls == 6) ? "R2 R6 both R8" : "R7 default R8";
        if (extra_tick) tag = {tag, " R11"};
        check(ne < n_cmd && cmd_addr[ne] == a[ADDR_W-1:0], tag,
              (ne < n_cmd) ? int'(cmd_addr[ne]) : -1, a);
        ne++;
      end
    end
    check(n_cmd == ne, extra_tick ? "R3 R11 command count" : "R3 command count", n_cmd, ne);
  endtask

  initial begin : main
    for (int b = 0; b < (1 << BANK_W); b++) last_cyc[b] = -1;
    m_bits[0] = '0;
    m_bits[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset with no tick
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); if (ref_req) seen++; end
      check(seen == 0, "R1 reset idle", seen, 0);
    end
    for (int i = 0; i < 8; i++) prog(PROG_TAB[i][9], PROG_TAB[i][8], PROG_TAB[i][7:0]);
    for (int w = 0; w < 4; w++) run_window(w, 1'b0);
    run_window(0, 1'b1);    // R11: ignored second tick keeps window 0
    run_window(1, 1'b0);
    prog(1'b0, 1'b1, '0);   // R12: clear fast filter only
    run_window(2, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule